// File: doc/BRIEF.md
# Interrupt Entry and Fetch Redirect Controller

This block sits beside the execute stage of a seven-stage in-order pipeline with a branch delay slot. The seven stages are pre-fetch, fetch, decode, execute, pre-data, data and writeback. Each cycle it decides whether a pending, enabled interrupt request may be taken against the instruction now in execute. When it takes one, that instruction completes. The three younger stages are flushed and fetch is steered to the single handler address 0x0040_000C. The address of the next sequential instruction is presented for the coprocessor to store as the resume point, and a one-cycle entry strobe tells the coprocessor to record it.

Any branch or jump opens a protection window. The window covers the delay slot and the two wrong-path instructions that follow. An interrupt is never taken while a branch or jump is in execute or while that window is open, so the resume address can never skip a redirect. This also covers the software return sequence. That sequence jumps to the saved address and sets the global enable from the jump's delay slot, and a pending request still waits until the jump has landed.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the protection window is closed, no interrupt is held off by a previous entry, `irq_enter` is low and `fetch_pc` equals `npc_seq`.
- R2: `irq_enter` is high in a cycle only if `irq_req`, `irq_glb_en` and `ex_valid` are all high, `ex_cti` is low, the window is closed and no earlier entry is still held. In a cycle that meets all of these it is high.
- R3: In an entry cycle `fetch_sel_vec` is 1 and `fetch_pc` is 0x0040_000C. In every other cycle `fetch_sel_vec` is 0 and `fetch_pc` equals `npc_seq`.
- R4: In an entry cycle `epc_save` equals `ex_pc` + 4.
- R5: `flush_young` bit 2 flushes pre-fetch, bit 1 flushes fetch and bit 0 flushes decode. All three bits are 1 in an entry cycle and all are 0 otherwise.
- R6: No entry occurs in a cycle where a valid branch or jump (`ex_cti`=1) is in execute.
- R7: After a valid branch or jump leaves execute, the next three valid instructions in execute cannot be interrupted. The fourth can be.
- R8: Cycles with `ex_valid` low do not advance the protection window.
- R9: A valid branch or jump inside the window reopens it for a full three valid instructions.
- R10: `irq_enter` lasts one cycle. Further entries are held off while `irq_glb_en` stays high. One cycle with `irq_glb_en` low releases the hold.
- R11: A jump whose delay slot raises `irq_glb_en` receives no entry on the delay slot or on the two instructions after it. The entry occurs on the third valid instruction after the delay slot.
- R12: With `irq_req` low, or `irq_glb_en` low, or `ex_valid` low, no entry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Pending and masked interrupt request from the coprocessor |
| irq_glb_en | input | 1 | Global interrupt enable |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_cti | input | 1 | Execute-stage instruction is a branch or jump, taken or not |
| ex_pc | input | 32 | Address of the execute-stage instruction |
| npc_seq | input | 32 | Next fetch address chosen by the normal next-PC logic |
| fetch_pc | output | 32 | Next fetch address after interrupt selection |
| fetch_sel_vec | output | 1 | High when fetch is steered to the handler |
| flush_young | output | 3 | Flush for pre-fetch (bit 2), fetch (bit 1) and decode (bit 0) |
| epc_save | output | 32 | Resume address to store on entry |
| irq_enter | output | 1 | One-cycle entry strobe to the coprocessor |

## Verification
Two functions can fall in the same cycle. A branch or jump may reach execute in the same cycle that a request is already pending and enabled, and the window may close in the same cycle that a request is waiting. The tests create both collisions on purpose: they hold the request high across a branch, through invalid bubbles, through a second branch inside the window, and across a return jump whose delay slot raises the enable. Each cycle is judged against the expected entry decision, fetch address, flush pattern and resume address. Entry must land on exactly the first instruction after the window closes.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int unsigned PC_W     = 32;
  localparam int unsigned WIN_LEN  = 3;
  localparam int unsigned FLUSH_N  = 3;
  localparam logic [PC_W-1:0] HANDLER_VEC = 32'h0040_000C;

  // Address of the instruction that follows pc sequentially
  function automatic logic [PC_W-1:0] seq_after(input logic [PC_W-1:0] pc);
    return pc + PC_W'(4);
  endfunction

  // Next value of the protection window counter
  function automatic logic [7:0] win_next(input logic [7:0] cur, input logic vld,
                                           input logic cti, input logic [7:0] len);
    if (vld && cti)              return len;
    else if (vld && cur != 8'd0) return cur - 8'd1;
    else                         return cur;
  endfunction
endpackage

// File: rtl/irq_defer_window.sv
module irq_defer_window #(
  parameter int unsigned WIN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ex_valid,
  input  logic ex_cti,
  output logic win_busy
);
  localparam int unsigned CW = $clog2(WIN_LEN + 1);

  logic [CW-1:0] cnt_q;
  logic [7:0]    nxt;

  always_comb nxt = irq_entry_pkg::win_next(8'(cnt_q), ex_valid, ex_cti, 8'(WIN_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt[CW-1:0];
  end

  assign win_busy = (cnt_q != '0);
endmodule

// File: rtl/irq_take_arb.sv
module irq_take_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic irq_glb_en,
  input  logic ex_valid,
  input  logic ex_cti,
  input  logic win_busy,
  output logic take,
  output logic held
);
  logic held_q;

  assign take = irq_req && irq_glb_en && ex_valid && !ex_cti && !win_busy && !held_q;
  assign held = held_q;

  // Hold off re-entry until the enable has been seen low once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           held_q <= 1'b0;
    else if (!irq_glb_en) held_q <= 1'b0;
    else if (take)        held_q <= 1'b1;
  end
endmodule

// File: rtl/irq_redirect.sv
module irq_redirect #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned FLUSH_N = 3,
  parameter logic [PC_W-1:0] VEC = 32'h0040_000C
) (
  input  logic              take,
  input  logic [PC_W-1:0]   ex_pc,
  input  logic [PC_W-1:0]   npc_seq,
  output logic [PC_W-1:0]   fetch_pc,
  output logic              fetch_sel_vec,
  output logic [FLUSH_N-1:0] flush_young,
  output logic [PC_W-1:0]   epc_save
);
  assign fetch_sel_vec = take;
  assign fetch_pc      = take ? VEC : npc_seq;
  assign epc_save      = irq_entry_pkg::seq_after(ex_pc);

  for (genvar g = 0; g < FLUSH_N; g++) begin : g_flush
    assign flush_young[g] = take;
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int unsigned PC_W    = irq_entry_pkg::PC_W,
  parameter int unsigned WIN_LEN = irq_entry_pkg::WIN_LEN,
  parameter int unsigned FLUSH_N = irq_entry_pkg::FLUSH_N,
  parameter logic [PC_W-1:0] VEC = irq_entry_pkg::HANDLER_VEC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_req,
  input  logic               irq_glb_en,
  input  logic               ex_valid,
  input  logic               ex_cti,
  input  logic [PC_W-1:0]    ex_pc,
  input  logic [PC_W-1:0]    npc_seq,
  output logic [PC_W-1:0]    fetch_pc,
  output logic               fetch_sel_vec,
  output logic [FLUSH_N-1:0] flush_young,
  output logic [PC_W-1:0]    epc_save,
  output logic               irq_enter
);
  logic win_busy;
  logic take;
  logic held;

  irq_defer_window #(.WIN_LEN(WIN_LEN)) win_i (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_cti(ex_cti), .win_busy(win_busy)
  );

  irq_take_arb arb_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_glb_en(irq_glb_en),
    .ex_valid(ex_valid), .ex_cti(ex_cti), .win_busy(win_busy), .take(take), .held(held)
  );

  irq_redirect #(.PC_W(PC_W), .FLUSH_N(FLUSH_N), .VEC(VEC)) rd_i (
    .take(take), .ex_pc(ex_pc), .npc_seq(npc_seq), .fetch_pc(fetch_pc),
    .fetch_sel_vec(fetch_sel_vec), .flush_young(flush_young), .epc_save(epc_save)
  );

  assign irq_enter = take;
endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned FLUSH_N = 3,
  parameter logic [PC_W-1:0] VEC = 32'h0040_000C
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_req,
  input logic               irq_glb_en,
  input logic               ex_valid,
  input logic               ex_cti,
  input logic [PC_W-1:0]    ex_pc,
  input logic [PC_W-1:0]    npc_seq,
  input logic [PC_W-1:0]    fetch_pc,
  input logic               fetch_sel_vec,
  input logic [FLUSH_N-1:0] flush_young,
  input logic [PC_W-1:0]    epc_save,
  input logic               irq_enter,
  input logic               win_busy,
  input logic               held
);
  // R2
  enter_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter |-> (irq_req && irq_glb_en && ex_valid && !held));
  // R3
  vec_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter |-> (fetch_sel_vec && fetch_pc == VEC));
  // R3
  seq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_enter |-> (!fetch_sel_vec && fetch_pc == npc_seq));
  // R4
  resume_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter |-> (epc_save == ex_pc + PC_W'(4)));
  // R5
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter ? (flush_young == '1) : (flush_young == '0));
  // R6
  cti_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_cti |-> !irq_enter);
  // R7
  window_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_busy |-> !irq_enter);
  // R7
  window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_cti) |=> win_busy);
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter |=> !irq_enter);
  // R10
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && irq_glb_en) |=> (held || !irq_glb_en));
endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(.PC_W(PC_W), .FLUSH_N(FLUSH_N), .VEC(VEC)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_glb_en(irq_glb_en),
  .ex_valid(ex_valid), .ex_cti(ex_cti), .ex_pc(ex_pc), .npc_seq(npc_seq),
  .fetch_pc(fetch_pc), .fetch_sel_vec(fetch_sel_vec), .flush_young(flush_young),
  .epc_save(epc_save), .irq_enter(irq_enter), .win_busy(win_busy), .held(held)
);

// File: tb/irq_entry_ctrl_tb.sv
`timescale 1ns/1ps
module irq_entry_ctrl_tb_top;
  localparam logic [31:0] VEC = 32'h0040_000C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0, irq_glb_en = 1'b0, ex_valid = 1'b0, ex_cti = 1'b0;
  logic [31:0] ex_pc = '0, npc_seq = '0;
  logic [31:0] fetch_pc, epc_save;
  logic        fetch_sel_vec, irq_enter;
  logic [2:0]  flush_young;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_glb_en(irq_glb_en),
    .ex_valid(ex_valid), .ex_cti(ex_cti), .ex_pc(ex_pc), .npc_seq(npc_seq),
    .fetch_pc(fetch_pc), .fetch_sel_vec(fetch_sel_vec), .flush_young(flush_young),
    .epc_save(epc_save), .irq_enter(irq_enter)
  );

  // Apply one execute-stage cycle; sampling happens 1 ns later, mid-cycle
  task automatic drive(input logic v, input logic c, input logic [31:0] pc,
                       input logic rq, input logic en);
    @(negedge clk);
    ex_valid = v; ex_cti = c; ex_pc = pc; npc_seq = pc + 32'h20;
    irq_req = rq; irq_glb_en = en;
    #1;
  endtask

  // Compare every output against the expected entry decision
  task automatic expect_cycle(input bit exp_enter, input string req);
    logic [31:0] exp_pc;
    logic [2:0]  exp_fl;
    bit ok;
    exp_pc = exp_enter ? VEC : npc_seq;
    exp_fl = exp_enter ? 3'b111 : 3'b000;
    ok = (irq_enter === exp_enter) && (fetch_sel_vec === exp_enter) &&
         (fetch_pc === exp_pc) && (flush_young === exp_fl) &&
         (!exp_enter || epc_save === ex_pc + 32'd4);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: enter=%0b sel=%0b pc=%h flush=%b epc=%h expected enter=%0b pc=%h flush=%b epc=%h",
               req, irq_enter, fetch_sel_vec, fetch_pc, flush_young, epc_save,
               exp_enter, exp_pc, exp_fl, ex_pc + 32'd4);
    end
  endtask

  task automatic release_hold();
    drive(1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
    expect_cycle(1'b0, "R12 idle");
  endtask

  task automatic t_reset();
    drive(1'b0, 1'b0, 32'h0000_0040, 1'b0, 1'b0);
    expect_cycle(1'b0, "R1 reset state");
    drive(1'b1, 1'b0, 32'h0000_0044, 1'b1, 1'b1);
    expect_cycle(1'b1, "R1 window closed after reset");
    release_hold();
  endtask

  task automatic t_basic();
    drive(1'b1, 1'b0, 32'h0000_0100, 1'b1, 1'b1);
    expect_cycle(1'b1, "R2 R3 R4 R5 basic entry");
    drive(1'b1, 1'b0, 32'h0000_0104, 1'b1, 1'b1);
    expect_cycle(1'b0, "R10 no retake while enable high");
    drive(1'b1, 1'b0, 32'h0000_0108, 1'b1, 1'b1);
    expect_cycle(1'b0, "R10 still held");
    drive(1'b1, 1'b0, 32'h0000_010C, 1'b1, 1'b0);
    expect_cycle(1'b0, "R12 enable low");
    drive(1'b1, 1'b0, 32'h0000_0110, 1'b1, 1'b1);
    expect_cycle(1'b1, "R10 re-armed after enable low");
    release_hold();
  endtask

  task automatic t_noreq();
    drive(1'b1, 1'b0, 32'h0000_0200, 1'b0, 1'b1);
    expect_cycle(1'b0, "R12 no request");
    drive(1'b1, 1'b0, 32'h0000_0204, 1'b1, 1'b0);
    expect_cycle(1'b0, "R12 disabled");
    drive(1'b0, 1'b0, 32'h0000_0208, 1'b1, 1'b1);
    expect_cycle(1'b0, "R12 invalid slot");
  endtask

  task automatic t_window();
    drive(1'b1, 1'b1, 32'h0000_0300, 1'b1, 1'b1);
    expect_cycle(1'b0, "R6 branch in execute");
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 1'b0, 32'h0000_0304 + 32'(4*i), 1'b1, 1'b1);
      expect_cycle(1'b0, "R7 inside window");
    end
    drive(1'b1, 1'b0, 32'h0000_0340, 1'b1, 1'b1);
    expect_cycle(1'b1, "R7 first after window");
    release_hold();
  endtask

  task automatic t_bubbles();
    drive(1'b1, 1'b1, 32'h0000_0400, 1'b0, 1'b1);
    expect_cycle(1'b0, "R6 branch no request");
    drive(1'b0, 1'b0, 32'h0, 1'b1, 1'b1);
    expect_cycle(1'b0, "R8 bubble");
    drive(1'b0, 1'b0, 32'h0, 1'b1, 1'b1);
    expect_cycle(1'b0, "R8 bubble");
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 1'b0, 32'h0000_0404 + 32'(4*i), 1'b1, 1'b1);
      expect_cycle(1'b0, "R8 window not advanced by bubbles");
    end
    drive(1'b1, 1'b0, 32'h0000_0480, 1'b1, 1'b1);
    expect_cycle(1'b1, "R8 entry after three valid");
    release_hold();
  endtask

  task automatic t_reload();
    drive(1'b1, 1'b1, 32'h0000_0500, 1'b1, 1'b1);
    expect_cycle(1'b0, "R6 first branch");
    drive(1'b1, 1'b0, 32'h0000_0504, 1'b1, 1'b1);
    expect_cycle(1'b0, "R9 delay slot");
    drive(1'b1, 1'b1, 32'h0000_0508, 1'b1, 1'b1);
    expect_cycle(1'b0, "R9 branch in window");
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 1'b0, 32'h0000_0600 + 32'(4*i), 1'b1, 1'b1);
      expect_cycle(1'b0, "R9 reopened window");
    end
    drive(1'b1, 1'b0, 32'h0000_0700, 1'b1, 1'b1);
    expect_cycle(1'b1, "R9 entry after reopened window");
    release_hold();
  endtask

  task automatic t_return();
    drive(1'b1, 1'b1, 32'h0040_0080, 1'b1, 1'b0);
    expect_cycle(1'b0, "R11 return jump");
    drive(1'b1, 1'b0, 32'h0040_0084, 1'b1, 1'b0);
    expect_cycle(1'b0, "R11 delay slot re-enables");
    drive(1'b1, 1'b0, 32'h0040_0088, 1'b1, 1'b1);
    expect_cycle(1'b0, "R11 killed slot one");
    drive(1'b1, 1'b0, 32'h0040_008C, 1'b1, 1'b1);
    expect_cycle(1'b0, "R11 killed slot two");
    drive(1'b1, 1'b0, 32'h0000_1234, 1'b1, 1'b1);
    expect_cycle(1'b1, "R11 entry at landed target");
    release_hold();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_noreq();
    t_window();
    t_bubbles();
    t_reload();
    t_return();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule